// File: doc/BRIEF.md
# Tune Command Mapper

This block turns the ten-byte data phase of a vendor tune request into the settings a satellite demodulator needs. The bytes arrive one per cycle with a valid strobe, and a separate marker flags the final byte of the transfer. Once a complete payload has been seen, the block keeps the symbol-rate and frequency words in most-significant-byte-first order. It also checks the modulation and FEC indices, and works out four configuration bytes: the FEC code, the modulation type, the demodulator mode and the turbo flag. Alongside these it keeps two status flags: one marks a DigiCipher-style tune, the other is a non-turbo indicator.

Software fills a 32-entry lookup RAM through a write port. Each modulation family reads its FEC codes from its own window of that RAM. A one-cycle `done` pulse reports a tune that was accepted. A one-cycle `err` pulse reports a malformed payload or an FEC index outside the family's range. A payload that arrives while the device is not started is absorbed without any effect.

Top module: `tune_cmd_mapper`

## Requirements
- R1: A payload is accepted only when the end marker comes with exactly the tenth byte. Byte order: 0-3 symbol rate (least significant byte first), 4-7 frequency (least significant byte first), 8 modulation index, 9 FEC index. All outputs update on the clock edge after the edge that samples the final byte.
- R2: `sym_be` and `freq_be` hold the words most significant byte first. Bits [31:24] are storage address 0 and carry payload byte 3 (or byte 7), and bits [7:0] carry byte 0 (or byte 4). Both words and the two indices are stored for every accepted payload that arrives while started is high.
- R3: While `started` is low, a complete payload changes no output, and neither `done` nor `err` pulses.
- R4: A modulation index of 10 or more pulses `done`, stores the words and indices, and leaves every configuration byte and flag unchanged.
- R5: The FEC index limits are 7 for index 0, 5 for index 1, 5 for index 2, 1 for index 3 and 9 for indices 4-7. An index at or above its limit pulses `err`, not `done`, and leaves the FEC code, modulation type, demodulator mode, turbo flag and DC-tuned flag unchanged.
- R6: Index 0 sets the FEC code from the table, the modulation type to 0x09, the demodulator mode to 0x10, the turbo flag to 0, and clears DC-tuned.
- R7: Indices 1, 2 and 3 (the turbo modes) set the FEC code from their table, the modulation type to 0x09, the demodulator mode to 0x10 and the turbo flag to 1, and clear DC-tuned.
- R8: Indices 4, 5, 6 and 7 set the demodulator mode to 0x10, 0x12, 0x16 and 0x11 in that order, the modulation type from the DCII table, the FEC code to 0xFC and the turbo flag to 0, and set DC-tuned.
- R9: Indices 8 and 9 never raise an error. An in-range FEC index (below 7) gives the table value OR 0x80, and any other index gives 0x8C. The modulation type becomes 0x09, the demodulator mode 0x10, and turbo and DC-tuned 0. This path clears `non_turbo`.
- R10: If the end marker comes before or after the tenth byte, `err` pulses and no other output changes. The next payload starts from byte 0.
- R11: The table address is the family base plus the FEC index. The bases are 0 (index 0 and indices 8/9), 7 (index 1), 12 (index 2), 17 (index 3) and 18 (indices 4-7). Entries are written through `tbl_we`/`tbl_addr`/`tbl_wdata`.
- R12: After reset all outputs are zero except `non_turbo`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| started | input | 1 | Device-started gate |
| pl_valid | input | 1 | Payload byte strobe |
| pl_data | input | 8 | Payload byte |
| pl_last | input | 1 | End-of-transfer marker on the current byte |
| tbl_we | input | 1 | Lookup RAM write enable |
| tbl_addr | input | 5 | Lookup RAM write address |
| tbl_wdata | input | 8 | Lookup RAM write data |
| sym_be | output | 32 | Symbol rate, address-0 byte in [31:24] |
| freq_be | output | 32 | Frequency, address-0 byte in [31:24] |
| mod_idx | output | 8 | Last stored modulation index |
| fec_idx | output | 8 | Last stored FEC index |
| fec_code | output | 8 | FEC code byte |
| mod_type | output | 8 | Modulation type byte |
| demod_mode | output | 8 | Demodulator mode byte |
| turbo | output | 1 | Turbo flag |
| dc_tuned | output | 1 | DigiCipher-style tune flag |
| non_turbo | output | 1 | Non-turbo indicator |
| done | output | 1 | Tune accepted pulse |
| err | output | 1 | Malformed payload or FEC index out of range |

## Verification
A byte counter that drifts from the true position would put fields in the wrong slots. It would also misjudge the end marker, so `err` would fire on a good payload, or `done` on a bad one, one cycle after the final byte. A wrong family decode or base offset would show at once as the wrong FEC code or modulation type in the same cycle as `done`, because every family is checked with table entries that differ by address. A stale flag such as DC-tuned or `non_turbo` only shows on the next tune of a different family, so the bench runs families back to back.

// File: rtl/tune_pkg.sv
package tune_pkg;
    localparam int PAYLOAD_LEN = 10;

    localparam logic [7:0] MOD_TYPE_STD = 8'h09;
    localparam logic [7:0] DEMOD_STD    = 8'h10;
    localparam logic [7:0] DC_FEC_CODE  = 8'hFC;
    localparam logic [7:0] ALT_DEFAULT  = 8'h8C;
    localparam logic [7:0] ALT_OR_MASK  = 8'h80;

    typedef struct packed {
        logic [31:0] sr;
        logic [31:0] fr;
        logic [7:0]  mod;
        logic [7:0]  fec;
    } frame_t;

    typedef enum logic [2:0] {
        FAM_STD,
        FAM_TURBO,
        FAM_DC,
        FAM_ALT,
        FAM_NONE
    } family_e;

    typedef struct packed {
        logic       upd;
        logic       err;
        logic [7:0] fec_code;
        logic [7:0] mod_type;
        logic [7:0] demod;
        logic       turbo;
        logic       dc;
        logic       nt_clr;
    } map_t;
endpackage

// File: rtl/tune_fec_ram.sv
module tune_fec_ram #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tune_frame_asm.sv
module tune_frame_asm
    import tune_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pl_valid,
    input  logic [7:0] pl_data,
    input  logic       pl_last,
    output frame_t     frame,
    output logic       frm_ok,
    output logic       frm_bad
);
    localparam int CW = $clog2(PAYLOAD_LEN + 6);

    typedef struct packed {
        logic [PAYLOAD_LEN-1:0][7:0] bytes;
        logic [CW-1:0]               cnt;
        logic                        ok;
        logic                        bad;
    } asm_t;

    asm_t q, d;

    always_comb begin
        d     = q;
        d.ok  = 1'b0;
        d.bad = 1'b0;
        if (pl_valid) begin
            for (int i = 0; i < PAYLOAD_LEN; i++) begin
                if (q.cnt == CW'(i)) d.bytes[i] = pl_data;
            end
            if (pl_last) begin
                d.cnt = '0;
                if (q.cnt == CW'(PAYLOAD_LEN - 1)) d.ok = 1'b1;
                else                               d.bad = 1'b1;
            end else if (q.cnt != '1) begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign frame.sr  = {q.bytes[3], q.bytes[2], q.bytes[1], q.bytes[0]};
    assign frame.fr  = {q.bytes[7], q.bytes[6], q.bytes[5], q.bytes[4]};
    assign frame.mod = q.bytes[8];
    assign frame.fec = q.bytes[9];
    assign frm_ok    = q.ok;
    assign frm_bad   = q.bad;

    // R10: a frame verdict is either good or bad, never both
    a_r10_verdict_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_ok && frm_bad));

    // R1: every verdict follows a byte that carried the end marker
    a_r1_verdict_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_ok || frm_bad) |-> $past(pl_valid && pl_last));
endmodule

// File: rtl/tune_cfg_map.sv
module tune_cfg_map
    import tune_pkg::*;
#(
    parameter logic [4:0] BASE_STD = 5'd0,
    parameter logic [4:0] BASE_TQ  = 5'd7,
    parameter logic [4:0] BASE_T8  = 5'd12,
    parameter logic [4:0] BASE_T16 = 5'd17,
    parameter logic [4:0] BASE_DC  = 5'd18
) (
    input  logic [7:0] mod,
    input  logic [7:0] fec,
    input  logic [7:0] tbl_rdata,
    output logic [4:0] tbl_raddr,
    output map_t       res
);
    family_e    fam;
    logic [7:0] lim;
    logic [4:0] base;
    logic       in_rng;

    always_comb begin
        fam  = FAM_NONE;
        lim  = 8'd0;
        base = BASE_STD;
        unique case (mod)
            8'd0:                   begin fam = FAM_STD;   lim = 8'd7; base = BASE_STD; end
            8'd1:                   begin fam = FAM_TURBO; lim = 8'd5; base = BASE_TQ;  end
            8'd2:                   begin fam = FAM_TURBO; lim = 8'd5; base = BASE_T8;  end
            8'd3:                   begin fam = FAM_TURBO; lim = 8'd1; base = BASE_T16; end
            8'd4, 8'd5, 8'd6, 8'd7: begin fam = FAM_DC;    lim = 8'd9; base = BASE_DC;  end
            8'd8, 8'd9:             begin fam = FAM_ALT;   lim = 8'd7; base = BASE_STD; end
            default:                begin fam = FAM_NONE;  end
        endcase
        in_rng    = (fec < lim);
        tbl_raddr = in_rng ? (base + fec[4:0]) : base;
    end

    always_comb begin
        res = '0;
        unique case (fam)
            FAM_STD, FAM_TURBO: begin
                if (in_rng) begin
                    res.upd      = 1'b1;
                    res.fec_code = tbl_rdata;
                    res.mod_type = MOD_TYPE_STD;
                    res.demod    = DEMOD_STD;
                    res.turbo    = (fam == FAM_TURBO);
                end else begin
                    res.err = 1'b1;
                end
            end
            FAM_DC: begin
                if (in_rng) begin
                    res.upd      = 1'b1;
                    res.fec_code = DC_FEC_CODE;
                    res.mod_type = tbl_rdata;
                    res.dc       = 1'b1;
                    unique case (mod[1:0])
                        2'd0:    res.demod = 8'h10;
                        2'd1:    res.demod = 8'h12;
                        2'd2:    res.demod = 8'h16;
                        default: res.demod = 8'h11;
                    endcase
                end else begin
                    res.err = 1'b1;
                end
            end
            FAM_ALT: begin
                res.upd      = 1'b1;
                res.nt_clr   = 1'b1;
                res.fec_code = in_rng ? (tbl_rdata | ALT_OR_MASK) : ALT_DEFAULT;
                res.mod_type = MOD_TYPE_STD;
                res.demod    = DEMOD_STD;
            end
            default: res = '0;
        endcase
    end

    // R5: a mapping either updates the configuration or reports an error
    always_comb begin
        a_r5_upd_err_excl: assert (!(res.upd && res.err));
    end
endmodule

// File: rtl/tune_cmd_mapper.sv
module tune_cmd_mapper
    import tune_pkg::*;
#(
    parameter int         TBL_DEPTH = 32,
    parameter logic [4:0] BASE_STD  = 5'd0,
    parameter logic [4:0] BASE_TQ   = 5'd7,
    parameter logic [4:0] BASE_T8   = 5'd12,
    parameter logic [4:0] BASE_T16  = 5'd17,
    parameter logic [4:0] BASE_DC   = 5'd18
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        started,
    input  logic        pl_valid,
    input  logic [7:0]  pl_data,
    input  logic        pl_last,
    input  logic        tbl_we,
    input  logic [4:0]  tbl_addr,
    input  logic [7:0]  tbl_wdata,
    output logic [31:0] sym_be,
    output logic [31:0] freq_be,
    output logic [7:0]  mod_idx,
    output logic [7:0]  fec_idx,
    output logic [7:0]  fec_code,
    output logic [7:0]  mod_type,
    output logic [7:0]  demod_mode,
    output logic        turbo,
    output logic        dc_tuned,
    output logic        non_turbo,
    output logic        done,
    output logic        err
);
    typedef struct packed {
        logic [31:0] sr;
        logic [31:0] fr;
        logic [7:0]  mod;
        logic [7:0]  fec;
        logic [7:0]  fec_code;
        logic [7:0]  mod_type;
        logic [7:0]  demod;
        logic        turbo;
        logic        dc;
        logic        nt;
        logic        done;
        logic        err;
    } st_t;

    frame_t     frame;
    logic       frm_ok, frm_bad;
    logic [4:0] tbl_raddr;
    logic [7:0] tbl_rdata;
    map_t       m;
    st_t        q, d;

    tune_frame_asm u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pl_valid(pl_valid),
        .pl_data (pl_data),
        .pl_last (pl_last),
        .frame   (frame),
        .frm_ok  (frm_ok),
        .frm_bad (frm_bad)
    );

    tune_fec_ram #(.DEPTH(TBL_DEPTH), .AW(5)) u_ram (
        .clk  (clk),
        .we   (tbl_we),
        .waddr(tbl_addr),
        .wdata(tbl_wdata),
        .raddr(tbl_raddr),
        .rdata(tbl_rdata)
    );

    tune_cfg_map #(
        .BASE_STD(BASE_STD), .BASE_TQ(BASE_TQ), .BASE_T8(BASE_T8),
        .BASE_T16(BASE_T16), .BASE_DC(BASE_DC)
    ) u_map (
        .mod      (frame.mod),
        .fec      (frame.fec),
        .tbl_rdata(tbl_rdata),
        .tbl_raddr(tbl_raddr),
        .res      (m)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        if (frm_bad) begin
            d.err = 1'b1;
        end else if (frm_ok && started) begin
            d.sr  = frame.sr;
            d.fr  = frame.fr;
            d.mod = frame.mod;
            d.fec = frame.fec;
            if (m.err) begin
                d.err = 1'b1;
            end else begin
                d.done = 1'b1;
                if (m.upd) begin
                    d.fec_code = m.fec_code;
                    d.mod_type = m.mod_type;
                    d.demod    = m.demod;
                    d.turbo    = m.turbo;
                    d.dc       = m.dc;
                end
                if (m.nt_clr) d.nt = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.nt <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sym_be     = q.sr;
    assign freq_be    = q.fr;
    assign mod_idx    = q.mod;
    assign fec_idx    = q.fec;
    assign fec_code   = q.fec_code;
    assign mod_type   = q.mod_type;
    assign demod_mode = q.demod;
    assign turbo      = q.turbo;
    assign dc_tuned   = q.dc;
    assign non_turbo  = q.nt;
    assign done       = q.done;
    assign err        = q.err;

    // R5: an error leaves the configuration bytes as they were
    a_r5_err_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(fec_code) && $stable(mod_type) && $stable(demod_mode)
                 && $stable(turbo) && $stable(dc_tuned)));

    // R3: a tune is only reported when the gate was open
    a_r3_done_needs_started: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(started));

    // R8: a DC-style tune always carries the fixed FEC code
    a_r8_dc_fixed_code: assert property (@(posedge clk) disable iff (!rst_n)
        dc_tuned |-> (fec_code == DC_FEC_CODE && !turbo));

    // R7: turbo implies the standard type and demodulator mode
    a_r7_turbo_std_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        turbo |-> (mod_type == MOD_TYPE_STD && demod_mode == DEMOD_STD));

    // R1: done and err never pulse together
    a_r1_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // R9: non_turbo only ever falls, never rises after reset
    a_r9_nt_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(non_turbo));
endmodule

// File: tb/tune_cmd_mapper_tb_top.sv
`timescale 1ns/1ps
module tune_cmd_mapper_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        started = 1'b1;
    logic        pl_valid = 1'b0;
    logic [7:0]  pl_data = 8'h00;
    logic        pl_last = 1'b0;
    logic        tbl_we = 1'b0;
    logic [4:0]  tbl_addr = '0;
    logic [7:0]  tbl_wdata = '0;
    logic [31:0] sym_be, freq_be;
    logic [7:0]  mod_idx, fec_idx, fec_code, mod_type, demod_mode;
    logic        turbo, dc_tuned, non_turbo, done, err;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tune_cmd_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .started(started),
        .pl_valid(pl_valid), .pl_data(pl_data), .pl_last(pl_last),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
        .sym_be(sym_be), .freq_be(freq_be), .mod_idx(mod_idx), .fec_idx(fec_idx),
        .fec_code(fec_code), .mod_type(mod_type), .demod_mode(demod_mode),
        .turbo(turbo), .dc_tuned(dc_tuned), .non_turbo(non_turbo),
        .done(done), .err(err)
    );

    function automatic logic [7:0] tv(input int a);
        return 8'(a * 37 + 11);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives n bytes starting at a falling edge; returns after the output edge.
    task automatic send(input logic [31:0] sr, input logic [31:0] fr,
                        input logic [7:0] m, input logic [7:0] f, input int n);
        for (int i = 0; i < n; i++) begin
            pl_valid = 1'b1;
            pl_last  = (i == n - 1);
            if (i < 4)       pl_data = sr[8*i +: 8];
            else if (i < 8)  pl_data = fr[8*(i-4) +: 8];
            else if (i == 8) pl_data = m;
            else if (i == 9) pl_data = f;
            else             pl_data = 8'hEE;
            @(negedge clk);
        end
        pl_valid = 1'b0;
        pl_last  = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R12 fec_code", {24'd0, fec_code}, 32'd0);
        chk("R12 mod_type", {24'd0, mod_type}, 32'd0);
        chk("R12 sym_be", sym_be, 32'd0);
        chk("R12 flags", {28'd0, turbo, dc_tuned, done, err}, 32'd0);
        chk("R12 non_turbo", {31'd0, non_turbo}, 32'd1);
    endtask

    task automatic t_std();
        send(32'h01C9_C380, 32'h0011_2A88, 8'd0, 8'd2, 10);
        chk("R1 done", {31'd0, done}, 32'd1);
        chk("R2 sym_be", sym_be, 32'h01C9_C380);
        chk("R2 sym msb at addr0", {24'd0, sym_be[31:24]}, 32'h01);
        chk("R2 freq_be", freq_be, 32'h0011_2A88);
        chk("R6 R11 fec_code", {24'd0, fec_code}, {24'd0, tv(2)});
        chk("R6 mod_type", {24'd0, mod_type}, 32'h09);
        chk("R6 demod", {24'd0, demod_mode}, 32'h10);
        chk("R6 turbo", {31'd0, turbo}, 32'd0);
        @(negedge clk);
        chk("R1 done single pulse", {31'd0, done}, 32'd0);
    endtask

    task automatic t_turbo();
        send(32'h1, 32'h2, 8'd2, 8'd4, 10);
        chk("R7 t8 fec_code", {24'd0, fec_code}, {24'd0, tv(16)});
        chk("R7 t8 turbo", {31'd0, turbo}, 32'd1);
        send(32'h1, 32'h2, 8'd1, 8'd0, 10);
        chk("R7 tq fec_code", {24'd0, fec_code}, {24'd0, tv(7)});
        send(32'h1, 32'h2, 8'd1, 8'd5, 10);
        chk("R5 tq limit err", {30'd0, err, done}, 32'd2);
        chk("R5 tq cfg kept", {24'd0, fec_code}, {24'd0, tv(7)});
        send(32'h1, 32'h2, 8'd3, 8'd0, 10);
        chk("R7 t16 fec_code", {24'd0, fec_code}, {24'd0, tv(17)});
        chk("R7 t16 demod", {24'd0, demod_mode}, 32'h10);
        send(32'h1, 32'h2, 8'd3, 8'd1, 10);
        chk("R5 t16 limit err", {31'd0, err}, 32'd1);
        chk("R5 t16 turbo kept", {31'd0, turbo}, 32'd1);
    endtask

    task automatic t_dc();
        logic [7:0] modes [4] = '{8'h10, 8'h12, 8'h16, 8'h11};
        for (int k = 0; k < 4; k++) begin
            send(32'h3, 32'h4, 8'(4 + k), 8'd8, 10);
            chk("R8 demod", {24'd0, demod_mode}, {24'd0, modes[k]});
            chk("R8 mod_type", {24'd0, mod_type}, {24'd0, tv(26)});
            chk("R8 fec_code", {24'd0, fec_code}, 32'hFC);
            chk("R8 dc turbo", {30'd0, dc_tuned, turbo}, 32'd2);
        end
        send(32'h3, 32'h4, 8'd5, 8'd9, 10);
        chk("R5 dc limit err", {31'd0, err}, 32'd1);
        chk("R5 dc flag kept", {31'd0, dc_tuned}, 32'd1);
        send(32'h3, 32'h4, 8'd0, 8'd0, 10);
        chk("R6 dc cleared", {31'd0, dc_tuned}, 32'd0);
        chk("R6 std mod_type", {24'd0, mod_type}, 32'h09);
    endtask

    task automatic t_alt();
        chk("R9 nt before", {31'd0, non_turbo}, 32'd1);
        send(32'h5, 32'h6, 8'd8, 8'd3, 10);
        chk("R9 or 0x80", {24'd0, fec_code}, {24'd0, tv(3) | 8'h80});
        chk("R9 nt cleared", {31'd0, non_turbo}, 32'd0);
        send(32'h5, 32'h6, 8'd9, 8'd7, 10);
        chk("R9 default", {24'd0, fec_code}, 32'h8C);
        chk("R9 no error", {30'd0, err, done}, 32'd1);
    endtask

    task automatic t_skip();
        send(32'hA5A5_0001, 32'h6, 8'd12, 8'd0, 10);
        chk("R4 done", {30'd0, err, done}, 32'd1);
        chk("R4 mod_idx", {24'd0, mod_idx}, 32'd12);
        chk("R4 sym stored", sym_be, 32'hA5A5_0001);
        chk("R4 cfg kept", {24'd0, fec_code}, 32'h8C);
    endtask

    task automatic t_gate();
        started = 1'b0;
        send(32'h0BAD_0BAD, 32'h7, 8'd0, 8'd1, 10);
        chk("R3 no pulse", {30'd0, err, done}, 32'd0);
        chk("R3 sym kept", sym_be, 32'hA5A5_0001);
        chk("R3 cfg kept", {24'd0, fec_code}, 32'h8C);
        started = 1'b1;
    endtask

    task automatic t_len();
        send(32'hDEAD_BEEF, 32'h8, 8'd0, 8'd1, 6);
        chk("R10 short err", {30'd0, err, done}, 32'd2);
        chk("R10 short sym kept", sym_be, 32'hA5A5_0001);
        send(32'hDEAD_BEEF, 32'h8, 8'd0, 8'd1, 11);
        chk("R10 long err", {31'd0, err}, 32'd1);
        chk("R10 long mod kept", {24'd0, mod_idx}, 32'd12);
        send(32'h1234_5678, 32'h8, 8'd0, 8'd1, 10);
        chk("R10 recovers", {31'd0, done}, 32'd1);
        chk("R10 recovers fec", {24'd0, fec_code}, {24'd0, tv(1)});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        for (int a = 0; a < 32; a++) begin
            tbl_we = 1'b1; tbl_addr = 5'(a); tbl_wdata = tv(a);
            @(negedge clk);
        end
        tbl_we = 1'b0;
        t_std();
        t_turbo();
        t_dc();
        t_alt();
        t_skip();
        t_gate();
        t_len();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule